// File: doc/BRIEF.md
# Vector Line Increment Streaming Engine

The engine walks a vector of 32-bit single-precision values in host memory one 64-byte line at a time. It adds exactly 1.0 to every element that lies inside the programmed length, and stores each result at the same line position in a second buffer. Reads and writes go through two independent memory-mapped masters, each 512 bits wide, with a 48-bit byte address. One master only reads and the other only writes. The engine assumes nothing about ordering between the two address spaces.

Software loads the source base, the destination base and the element count through a small register-write port, then pulses `start`. The read master fetches lines in bursts of at most four lines, and only while the internal line buffer has room for the whole burst. Each returning line is split into 16 lanes that are incremented in parallel. The line is then queued. The write master drains the queue in bursts of the same shape, and the engine pulses `done` once the last write beat has been accepted.

Top module: `vline_inc_engine`

## Requirements
- R1: After reset, `rd_read`, `wr_write` and `done` are low.
- R2: Both masters address line n of a run at base + 64*n, with the low 6 address bits zero. Lines are fetched and stored in increasing order, and exactly ceil(count/16) lines are read and written.
- R3: Every burst has a burstcount of min(4, lines left to issue on that master). So every burst is 4 lines long except a shorter final one.
- R4: Lane i of a line holds bits [32*i+31:32*i] and element index line*16+i. For a normal input, the written value is the IEEE single-precision sum input + 1.0, rounded to nearest-even.
- R5: A NaN input is written as a quiet NaN (bit 22 set, sign and other payload bits kept). An infinity is written unchanged. A zero or denormal input of either sign is written as 1.0 (0x3F800000).
- R6: Lanes whose element index is not less than the count are written as 0x00000000.
- R7: While waitrequest is high, each master holds its request together with its address and burstcount. The write master also holds its write data. Write byteenable is all ones, and the beats of a write burst follow one another with `wr_write` held high.
- R8: Read data is accepted in any cycle after the read command. No more than 16 lines, which is 4 full bursts, are ever requested and not yet passed on to the write side.
- R9: `done` is high for exactly one cycle. That cycle is the one right after the final write beat is accepted.
- R10: A start with count 0 raises `done` without any read or write transaction. Neither master issues a request while no run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source base, 1 destination base, 2 element count |
| cfg_wdata | input | 48 | Register write data (bases use bits 47:6, count uses bits 31:0) |
| start | input | 1 | Start pulse, taken only while no run is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_read | output | 1 | Read request |
| rd_address | output | 48 | Read byte address, line aligned |
| rd_burstcount | output | 3 | Read burst length in lines |
| rd_waitrequest | input | 1 | Read command stall |
| rd_readdata | input | 512 | Read data line |
| rd_readdatavalid | input | 1 | Read data valid |
| wr_write | output | 1 | Write request |
| wr_address | output | 48 | Write byte address, line aligned |
| wr_burstcount | output | 3 | Write burst length in lines |
| wr_writedata | output | 512 | Write data line |
| wr_byteenable | output | 64 | Byte enables, all ones |
| wr_waitrequest | input | 1 | Write stall |

## Verification
The lane adder is exercised with random values over the full exponent range. These are mixed with directed values: exact ties such as 2^24 + 1, an exact 2^23 + 1, -1.0 cancelling to zero, the largest finite value, NaNs, infinities, signed zeros and denormals. This separates rounding, normalisation and special-case handling. Counts of 0, 1, 16, 17 and up to 1000 cover the empty-run path, partial tail lines, the short final burst and runs long enough to fill the line buffer. Running these with no stalls and with heavy random waitrequest and readdatavalid gaps separates correct credit and hold behaviour from behaviour that only works at full rate.

// File: rtl/vline_pkg.sv
package vline_pkg;
  localparam int LANES      = 16;
  localparam int LANE_W     = 32;
  localparam int LINE_W     = LANES * LANE_W;
  localparam int ADDR_W     = 48;
  localparam int OFS_W      = $clog2(LINE_W / 8);
  localparam int LANE_IDX_W = $clog2(LANES);

  // Single-precision x + 1.0, round to nearest-even, denormals read as zero.
  function automatic logic [31:0] fp_add_one(input logic [31:0] x);
    logic        s, bsign;
    logic [7:0]  e;
    logic [22:0] m, mb, ms;
    int          eb, es, d, p, er;
    logic [50:0] a, b, sh, sum, nrm;
    logic [23:0] rm;
    logic        rup;
    s = x[31];
    e = x[30:23];
    m = x[22:0];
    if (e == 8'hFF) return (m != 23'd0) ? {s, 8'hFF, 1'b1, m[21:0]} : x;
    if (e == 8'h00) return 32'h3F80_0000;
    if ({e, m} >= {8'd127, 23'd0}) begin
      eb = int'(e); mb = m; es = 127; ms = 23'd0; bsign = s;
    end else begin
      eb = 127; mb = 23'd0; es = int'(e); ms = m; bsign = 1'b0;
    end
    d = eb - es;
    a = {2'b01, mb, 26'd0};
    b = {2'b01, ms, 26'd0};
    if (d > 50) sh = 51'd1;
    else begin
      sh = b >> d;
      sh[0] = sh[0] | (|(b & ((51'd1 << d) - 51'd1)));
    end
    sum = s ? (a - sh) : (a + sh);
    if (sum == 51'd0) return 32'h0000_0000;
    p = 0;
    for (int i = 0; i < 51; i++) if (sum[i]) p = i;
    if (p == 50) nrm = (sum >> 1) | {50'd0, sum[0]};
    else nrm = sum << (49 - p);
    er = eb + p - 49;
    rup = nrm[25] & ((|nrm[24:0]) | nrm[26]);
    rm = {1'b0, nrm[48:26]} + {23'd0, rup};
    if (rm[23]) er = er + 1;
    if (er >= 255) return {bsign, 8'hFF, 23'd0};
    return {bsign, er[7:0], rm[22:0]};
  endfunction
endpackage

// File: rtl/vline_lane_inc.sv
module vline_lane_inc
  import vline_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LIDX_W = CNT_W - LANE_IDX_W + 1
) (
  input  logic [LINE_W-1:0] din,
  input  logic [LIDX_W-1:0] lidx,
  input  logic [CNT_W-1:0]  count,
  output logic [LINE_W-1:0] dout
);
  localparam int EIDX_W = LIDX_W + LANE_IDX_W;

  logic [EIDX_W-1:0] count_x;
  assign count_x = EIDX_W'(count);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [EIDX_W-1:0] eidx;
    logic              lane_live;
    assign eidx      = {lidx, LANE_IDX_W'(i)};
    assign lane_live = eidx < count_x;
    assign dout[i*LANE_W +: LANE_W] = lane_live ? fp_add_one(din[i*LANE_W +: LANE_W])
                                                : '0;
  end
endmodule

// File: rtl/vline_fifo.sv
module vline_fifo #(
  parameter int W     = 512,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full;

  assign full = (cnt == CW'(DEPTH));
  assign dout = mem[rp];

  always_ff @(posedge clk) if (push) mem[wp] <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
endmodule

// File: rtl/vline_rd_master.sv
module vline_rd_master
  import vline_pkg::*;
#(
  parameter int LIDX_W    = 29,
  parameter int MAX_BURST = 4,
  parameter int DEPTH     = 16,
  localparam int BC_W     = $clog2(MAX_BURST) + 1,
  localparam int PEND_W   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic [LIDX_W-1:0] nlines,
  input  logic              pop,
  output logic              rd_read,
  output logic [ADDR_W-1:0] rd_address,
  output logic [BC_W-1:0]   rd_burstcount,
  input  logic              rd_waitrequest,
  input  logic              rd_readdatavalid,
  output logic [LIDX_W-1:0] rx_idx
);
  logic              run;
  logic [LIDX_W-1:0] issued, remain;
  logic [BC_W-1:0]   blen;
  logic [PEND_W-1:0] pend;
  logic              issue, cmd_acc;

  assign remain  = nlines - issued;
  assign blen    = (remain >= LIDX_W'(MAX_BURST)) ? BC_W'(MAX_BURST) : remain[BC_W-1:0];
  assign issue   = run && !rd_read && (issued != nlines) && (int'(pend) + int'(blen) <= DEPTH);
  assign cmd_acc = rd_read && !rd_waitrequest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; issued <= '0; rx_idx <= '0; pend <= '0;
      rd_read <= 1'b0; rd_address <= '0; rd_burstcount <= '0;
    end else begin
      if (go) begin
        run <= 1'b1; issued <= '0; rx_idx <= '0;
      end else begin
        if (issue) begin
          rd_read       <= 1'b1;
          rd_address    <= base + ADDR_W'({issued, {OFS_W{1'b0}}});
          rd_burstcount <= blen;
          issued        <= issued + LIDX_W'(blen);
        end else if (cmd_acc) begin
          rd_read <= 1'b0;
          if (issued == nlines) run <= 1'b0;
        end
        if (rd_readdatavalid) rx_idx <= rx_idx + 1'b1;
      end
      pend <= pend + (issue ? PEND_W'(blen) : '0) - (pop ? PEND_W'(1) : '0);
    end
  end

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_read && rd_waitrequest) |=> (rd_read && $stable(rd_address) && $stable(rd_burstcount)));
  assert_rd_credit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend) <= DEPTH);
  assert_rd_bc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_read |-> (rd_burstcount != '0 && int'(rd_burstcount) <= MAX_BURST));
endmodule

// File: rtl/vline_wr_master.sv
module vline_wr_master
  import vline_pkg::*;
#(
  parameter int LIDX_W    = 29,
  parameter int MAX_BURST = 4,
  parameter int DEPTH     = 16,
  localparam int BC_W     = $clog2(MAX_BURST) + 1,
  localparam int CW       = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic [LIDX_W-1:0] nlines,
  input  logic [CW-1:0]     fifo_cnt,
  input  logic [LINE_W-1:0] fifo_dout,
  output logic              pop,
  output logic              last_acc,
  output logic              wr_write,
  output logic [ADDR_W-1:0] wr_address,
  output logic [BC_W-1:0]   wr_burstcount,
  output logic [LINE_W-1:0] wr_writedata,
  output logic [LINE_W/8-1:0] wr_byteenable,
  input  logic              wr_waitrequest
);
  logic              run;
  logic [LIDX_W-1:0] wline, remain;
  logic [BC_W-1:0]   blen, beats;
  logic              startb;

  assign remain   = nlines - wline;
  assign blen     = (remain >= LIDX_W'(MAX_BURST)) ? BC_W'(MAX_BURST) : remain[BC_W-1:0];
  assign startb   = run && !wr_write && (wline != nlines) && (int'(fifo_cnt) >= int'(blen));
  assign pop      = wr_write && !wr_waitrequest;
  assign last_acc = pop && (beats == BC_W'(1)) && (wline == nlines);
  assign wr_writedata  = fifo_dout;
  assign wr_byteenable = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; wline <= '0; beats <= '0;
      wr_write <= 1'b0; wr_address <= '0; wr_burstcount <= '0;
    end else if (go) begin
      run <= 1'b1; wline <= '0;
    end else if (startb) begin
      wr_write      <= 1'b1;
      wr_address    <= base + ADDR_W'({wline, {OFS_W{1'b0}}});
      wr_burstcount <= blen;
      beats         <= blen;
      wline         <= wline + LIDX_W'(blen);
    end else if (pop) begin
      beats <= beats - 1'b1;
      if (beats == BC_W'(1)) begin
        wr_write <= 1'b0;
        if (wline == nlines) run <= 1'b0;
      end
    end
  end

  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_write && wr_waitrequest) |=> (wr_write && $stable(wr_address) &&
                                     $stable(wr_burstcount) && $stable(wr_writedata)));
  assert_wr_bc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_write |-> (wr_burstcount != '0 && int'(wr_burstcount) <= MAX_BURST));
endmodule

// File: rtl/vline_inc_engine.sv
module vline_inc_engine
  import vline_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int MAX_BURST = 4,
  parameter int MAX_OUTST = 4,
  localparam int DEPTH    = MAX_BURST * MAX_OUTST,
  localparam int LIDX_W   = CNT_W - LANE_IDX_W + 1,
  localparam int BC_W     = $clog2(MAX_BURST) + 1,
  localparam int CW       = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_sel,
  input  logic [ADDR_W-1:0]   cfg_wdata,
  input  logic                start,
  output logic                done,
  output logic                rd_read,
  output logic [ADDR_W-1:0]   rd_address,
  output logic [BC_W-1:0]     rd_burstcount,
  input  logic                rd_waitrequest,
  input  logic [LINE_W-1:0]   rd_readdata,
  input  logic                rd_readdatavalid,
  output logic                wr_write,
  output logic [ADDR_W-1:0]   wr_address,
  output logic [BC_W-1:0]     wr_burstcount,
  output logic [LINE_W-1:0]   wr_writedata,
  output logic [LINE_W/8-1:0] wr_byteenable,
  input  logic                wr_waitrequest
);
  logic [ADDR_W-1:OFS_W] src_line, dst_line;
  logic [CNT_W-1:0]      count;
  logic [CNT_W:0]        count_up;
  logic [LIDX_W-1:0]     nlines, rx_idx;
  logic                  busy, go, zero_go, pop, last_acc;
  logic [LINE_W-1:0]     inc_line, fifo_dout;
  logic [CW-1:0]         fifo_cnt;

  assign count_up = {1'b0, count} + (CNT_W + 1)'(LANES - 1);
  assign nlines   = count_up[CNT_W:LANE_IDX_W];
  assign go       = start && !busy && (count != '0);
  assign zero_go  = start && !busy && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_line <= '0; dst_line <= '0; count <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          2'd0:    src_line <= cfg_wdata[ADDR_W-1:OFS_W];
          2'd1:    dst_line <= cfg_wdata[ADDR_W-1:OFS_W];
          2'd2:    count    <= cfg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (go) busy <= 1'b1;
      else if (last_acc) busy <= 1'b0;
      done <= last_acc || zero_go;
    end
  end

  vline_rd_master #(.LIDX_W(LIDX_W), .MAX_BURST(MAX_BURST), .DEPTH(DEPTH)) u_rd (
    .clk, .rst_n, .go, .base({src_line, {OFS_W{1'b0}}}), .nlines, .pop,
    .rd_read, .rd_address, .rd_burstcount, .rd_waitrequest, .rd_readdatavalid, .rx_idx);

  vline_lane_inc #(.CNT_W(CNT_W), .LIDX_W(LIDX_W)) u_lanes (
    .din(rd_readdata), .lidx(rx_idx), .count, .dout(inc_line));

  vline_fifo #(.W(LINE_W), .DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n, .push(rd_readdatavalid), .din(inc_line), .pop, .dout(fifo_dout), .cnt(fifo_cnt));

  vline_wr_master #(.LIDX_W(LIDX_W), .MAX_BURST(MAX_BURST), .DEPTH(DEPTH)) u_wr (
    .clk, .rst_n, .go, .base({dst_line, {OFS_W{1'b0}}}), .nlines, .fifo_cnt, .fifo_dout,
    .pop, .last_acc, .wr_write, .wr_address, .wr_burstcount, .wr_writedata, .wr_byteenable,
    .wr_waitrequest);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_read && !wr_write));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/vline_inc_engine_test.sv
module vline_inc_engine_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_sel = '0;
  logic [47:0]  cfg_wdata = '0;
  logic         start = 1'b0;
  logic         done;
  logic         rd_read, wr_write;
  logic [47:0]  rd_address, wr_address;
  logic [2:0]   rd_burstcount, wr_burstcount;
  logic         rd_waitrequest = 1'b0, wr_waitrequest = 1'b0, rd_readdatavalid = 1'b0;
  logic [511:0] rd_readdata = '0;
  logic [511:0] wr_writedata;
  logic [63:0]  wr_byteenable;

  localparam logic [47:0] RBASE = 48'h0012_3400_0040;
  localparam logic [47:0] WBASE = 48'h0000_8000_0000;

  always #2 clk = ~clk;

  vline_inc_engine uut (.*);

  int total = 0, bad = 0, cyc = 0, stall_pct = 0;
  logic [511:0] rmem [64];
  logic [511:0] wmem [64];
  int beatq[$];
  int cur_nl = 0, rline_exp = 0, wline_exp = 0, wbeat = 0, wbc_cur = 0;
  int rd_addr_bad = 0, wr_addr_bad = 0, bc_bad = 0, hold_bad = 0, gap_bad = 0, be_bad = 0;
  int inflight_bad = 0, done_cnt = 0, done_cyc = 0, acc_cyc = 0, txn_cnt = 0;
  bit hold_pend = 0;
  logic [47:0] h_addr; logic [2:0] h_bc; logic [511:0] h_data;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  function automatic real to_real(input logic [31:0] x);
    return $bitstoreal({x[31], 11'(int'(x[30:23]) - 127 + 1023), x[22:0], 29'd0});
  endfunction

  function automatic logic [31:0] to_single(input real r);
    logic [63:0] bits; int e32; logic [23:0] mm;
    if (r == 0.0) return 32'h0;
    bits = $realtobits(r);
    e32 = int'(bits[62:52]) - 1023 + 127;
    mm = {1'b0, bits[51:29]};
    if (bits[28] && ((|bits[27:0]) || bits[29])) mm = mm + 24'd1;
    if (mm[23]) e32 = e32 + 1;
    return {bits[63], e32[7:0], mm[22:0]};
  endfunction

  function automatic logic [31:0] want_inc(input logic [31:0] x);
    int e; e = int'(x[30:23]);
    if (e == 255) return (x[22:0] != 0) ? (x | 32'h0040_0000) : x;
    if (e == 0 || e < 98) return 32'h3F80_0000;
    if (e > 156) return x;
    return to_single(to_real(x) + 1.0);
  endfunction

  function automatic logic [31:0] rand_elem();
    int k; k = $urandom_range(0, 99);
    if (k < 4) return {$urandom_range(0, 1) == 1, 8'h00, 23'($urandom)};
    if (k < 8) return {$urandom_range(0, 1) == 1, 8'hFF, (k < 6) ? 23'd0 : 23'($urandom)};
    if (k < 60) return {$urandom_range(0, 1) == 1, 8'($urandom_range(98, 156)), 23'($urandom)};
    return {$urandom_range(0, 1) == 1, 8'($urandom_range(1, 254)), 23'($urandom)};
  endfunction

  // memory-side models for both masters
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (done) begin done_cnt++; done_cyc = cyc; end
      if (hold_pend && (!wr_write || wr_address != h_addr || wr_burstcount != h_bc || wr_writedata != h_data))
        hold_bad++;
      hold_pend = wr_write && wr_waitrequest;
      h_addr = wr_address; h_bc = wr_burstcount; h_data = wr_writedata;
      if (wr_write && !wr_waitrequest) begin
        txn_cnt++;
        if (wr_byteenable != '1) be_bad++;
        if (wbeat == 0) begin
          if (wr_address != WBASE + 48'(wline_exp * 64)) wr_addr_bad++;
          if (int'(wr_burstcount) != ((cur_nl - wline_exp) < 4 ? cur_nl - wline_exp : 4)) bc_bad++;
          wbc_cur = int'(wr_burstcount);
        end
        if (wline_exp < 64) wmem[wline_exp] = wr_writedata;
        wline_exp++; wbeat++;
        if (wbeat >= wbc_cur) wbeat = 0;
        acc_cyc = cyc;
      end else if (wbeat != 0 && !wr_write) gap_bad++;
      if (rd_readdatavalid && beatq.size() > 0) void'(beatq.pop_front());
      if (rd_read && !rd_waitrequest) begin
        txn_cnt++;
        if (rd_address != RBASE + 48'(rline_exp * 64)) rd_addr_bad++;
        if (int'(rd_burstcount) != ((cur_nl - rline_exp) < 4 ? cur_nl - rline_exp : 4)) bc_bad++;
        for (int k = 0; k < int'(rd_burstcount); k++) beatq.push_back(rline_exp + k);
        rline_exp += int'(rd_burstcount);
      end
      if (beatq.size() > 16) inflight_bad++;
      #1;
      rd_waitrequest = ($urandom_range(0, 99) < stall_pct);
      wr_waitrequest = ($urandom_range(0, 99) < stall_pct);
      if (beatq.size() > 0 && $urandom_range(0, 99) >= stall_pct) begin
        rd_readdatavalid = 1'b1;
        rd_readdata = rmem[beatq[0] % 64];
      end else begin
        rd_readdatavalid = 1'b0;
        rd_readdata = '0;
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [47:0] data);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic run_case(input int count, input int stall, input bit directed);
    logic [31:0] dv [12];
    logic [31:0] x, got, want;
    int nl, lane_bad, tail_bad;
    logic [31:0] fa, fe;
    dv = '{32'h7F80_0001, 32'hFF80_0000, 32'h7F80_0000, 32'h0000_0001,
           32'h8000_0000, 32'hBF80_0000, 32'h3F80_0000, 32'h7F7F_FFFF,
           32'h4B80_0000, 32'h4B00_0000, 32'hFFC0_1234, 32'hBFC0_0000};
    nl = (count + 15) / 16;
    for (int l = 0; l < 64; l++) begin
      for (int i = 0; i < 16; i++) begin
        x = rand_elem();
        if (directed && l * 16 + i < 12) x = dv[l * 16 + i];
        rmem[l][i*32 +: 32] = x;
      end
      wmem[l] = {16{32'hDEAD_BEEF}};
    end
    beatq.delete();
    cur_nl = nl; rline_exp = 0; wline_exp = 0; wbeat = 0; done_cnt = 0; txn_cnt = 0;
    rd_addr_bad = 0; wr_addr_bad = 0; bc_bad = 0; hold_bad = 0; gap_bad = 0; be_bad = 0;
    inflight_bad = 0; stall_pct = stall;
    cfg_write(2'd0, RBASE);
    cfg_write(2'd1, WBASE);
    cfg_write(2'd2, 48'(count));
    @(posedge clk); #1; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    while (done_cnt == 0) @(posedge clk);
    repeat (8) @(posedge clk);
    #1;
    chk(done_cnt == 1, "R9 single done pulse", 64'(done_cnt), 64'd1);
    if (count == 0) begin
      chk(txn_cnt == 0, "R10 zero count issues no transaction", 64'(txn_cnt), 64'd0);
    end else begin
      chk(done_cyc == acc_cyc + 1, "R9 done one cycle after last write", 64'(done_cyc), 64'(acc_cyc + 1));
    end
    chk(rline_exp == nl && wline_exp == nl, "R2 line counts read/written",
        {32'(rline_exp), 32'(wline_exp)}, {32'(nl), 32'(nl)});
    chk(rd_addr_bad == 0 && wr_addr_bad == 0, "R2 line addresses", 64'(rd_addr_bad + wr_addr_bad), 64'd0);
    chk(bc_bad == 0, "R3 burst lengths", 64'(bc_bad), 64'd0);
    chk(hold_bad == 0 && gap_bad == 0 && be_bad == 0, "R7 write hold, gaps, byteenable",
        64'(hold_bad * 65536 + gap_bad * 256 + be_bad), 64'd0);
    chk(inflight_bad == 0 && beatq.size() == 0, "R8 in-flight lines bounded",
        64'(inflight_bad), 64'd0);
    for (int l = 0; l < nl; l++) begin
      lane_bad = 0; tail_bad = 0; fa = 0; fe = 0;
      for (int i = 0; i < 16; i++) begin
        got = wmem[l][i*32 +: 32];
        if (l * 16 + i < count) begin
          want = want_inc(rmem[l][i*32 +: 32]);
          if (got != want) begin
            if (lane_bad == 0) begin fa = got; fe = want; end
            lane_bad++;
          end
        end else if (got != 32'h0) tail_bad++;
      end
      chk(lane_bad == 0, directed ? "R4 R5 lane increment (directed)" : "R4 lane increment",
          {32'(l), fa}, {32'(l), fe});
      if (count % 16 != 0 && l == nl - 1)
        chk(tail_bad == 0, "R6 tail lanes zero", 64'(tail_bad), 64'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk(!rd_read && !wr_write && !done, "R1 reset state",
        {61'd0, rd_read, wr_write, done}, 64'd0);
    run_case(0, 0, 1'b0);
    run_case(12, 0, 1'b1);
    run_case(12, 40, 1'b1);
    run_case(1, 0, 1'b0);
    run_case(16, 30, 1'b0);
    run_case(17, 30, 1'b0);
    run_case(100, 0, 1'b0);
    run_case(1000, 0, 1'b1);
    run_case(1000, 60, 1'b0);
    run_case(0, 50, 1'b0);
    for (int t = 0; t < 8; t++)
      run_case($urandom_range(1, 1000), $urandom_range(0, 70), 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule